// File: doc/BRIEF.md
# Parallel NOR flash command sequencer

This block interprets the bus write cycles of a parallel NOR flash model that uses the classic two-cycle unlock protocol. It watches a simple synchronous memory port, recognises unlock pairs and command codes, and picks what a read returns: the memory array, the identification words, the parameter query table, or an erase status word. Programs are applied directly to a small internal array as a bitwise AND. Erase requests go out to a separate erase controller as a one-cycle request with a chip/sector qualifier. The block waits in the erase state until that controller reports completion.

The host sends commands as ordinary writes. The low byte of the write data carries the command code, and the word offset derived from the byte address qualifies the cycle. The unlock offsets, identification values, bus width, array depth and sector size are elaboration parameters. After reset the block is in read-array mode and the array holds all ones.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in read-array mode: a read returns the array word (all ones in every word), and erase_req_o is low.
- R2: A command begins with data 0xAA at word offset UNLOCK0 (0x555 by default), then data 0x55 at UNLOCK1 (0x2AA by default). A wrong address or value in either cycle returns the block to read-array mode.
- R3: The cycle after a valid unlock, at UNLOCK0, selects 0xA0 program, 0x90 autoselect, 0x80 erase setup or 0x20 unlock bypass. Any other code returns the block to read-array mode.
- R4: A program cycle stores the AND of the written data and the current word, so programming only clears bits.
- R5: In unlock bypass the command cycle needs no unlock pair and its address is not checked. After a program the block waits for the next command rather than returning to read mode. Writing 0x00 while in autoselect under bypass exits bypass to read-array mode.
- R6: Data 0x98 at word offset 0x55 in read-array mode enters query mode. There a read at word offset n returns table byte n for n < 0x4D, and 0 otherwise; bytes 0x10..0x12 are 0x51, 0x52, 0x59 and byte 0x27 is log2 of the array size in bytes. Any write in query mode returns to read-array mode.
- R7: Data 0x98 at offset 0x55 in autoselect enters a nested query mode. There, data 0xF0 goes back to autoselect rather than to read mode.
- R8: Data 0xF0 returns the block to read-array mode and clears bypass in every state except program-data and erase-in-progress. In the program-data state 0xF0 is programmed like any other data.
- R9: In autoselect, word offsets 0 and 1 read ID0 and ID1, and offset 2 reads 0. Offsets 0x0E and 0x0F read ID2 and ID3, unless that value is all ones, in which case they read the array word. Every other offset reads the array word.
- R10: Erase needs 0x80, then a second 0xAA/0x55 unlock pair, then either 0x10 at UNLOCK0 (chip erase) or 0x30 at any address (erase of the sector holding that word). The block raises erase_req_o for exactly one cycle, with erase_all_o and erase_sect_o valid, and sets the affected words to all ones. 0x10 at any other address returns the block to read mode with no request.
- R11: While an erase is in progress, writes (including 0xF0) are ignored. Each read returns a status word in which bit 7 = 0 and bit 3 = 1, and bits 6 and 2 toggle on every status read, starting at 1, so successive reads give 0x4C, 0x08, 0x4C. A one-cycle erase_done_i returns the block to read-array mode, or to command wait if bypass is active.
- R12: The word offset used for matching is the byte address shifted right by log2 of the bus width in bytes (1 for the default 16-bit bus), keeping 11 bits. A write at the unshifted byte address 0x555 does not count as an unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data; low byte carries the command code |
| we_i | input | 1 | Write strobe, one cycle per bus write |
| re_i | input | 1 | Read strobe; rdata_o is updated at the same edge |
| rdata_o | output | DATA_W | Read data, registered |
| erase_req_o | output | 1 | One-cycle erase request |
| erase_all_o | output | 1 | Request is a chip erase |
| erase_sect_o | output | SECT_W | Sector index of a sector erase |
| erase_done_i | input | 1 | Erase controller reports completion |

## Verification
Assertions check on every cycle the transitions that follow a single write: a wrong second unlock cycle lands in read mode, any write in query mode leaves it, and 0xF0 in nested query returns to autoselect. They also check that the erase state holds against writes until completion, that the erase request lasts one cycle, and that a program never sets a bit. Only the bench scenarios can show the end-to-end content seen through reads: the identification and table values, the fall-back to array data when an ID is all ones, the sector boundaries of an erase, the status toggle sequence, and bypass leaving and keeping its command wait. Random programs with readback compare the array against a bench-side model.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [3:0] {
    ST_READ     = 4'd0,
    ST_UNL1     = 4'd1,
    ST_CMD      = 4'd2,
    ST_PROG     = 4'd3,
    ST_AUTO     = 4'd4,
    ST_ERS_UNL0 = 4'd5,
    ST_ERS_UNL1 = 4'd6,
    ST_ERS_CMD  = 4'd7,
    ST_ERASING  = 4'd8,
    ST_QRY      = 4'd9,
    ST_AUTO_QRY = 4'd10
  } seq_state_e;

  localparam logic [7:0] C_UNLOCK_A = 8'hAA;
  localparam logic [7:0] C_UNLOCK_B = 8'h55;
  localparam logic [7:0] C_ERASE    = 8'h80;
  localparam logic [7:0] C_AUTOSEL  = 8'h90;
  localparam logic [7:0] C_PROGRAM  = 8'hA0;
  localparam logic [7:0] C_BYPASS   = 8'h20;
  localparam logic [7:0] C_QUERY    = 8'h98;
  localparam logic [7:0] C_RESET    = 8'hF0;
  localparam logic [7:0] C_CHIP_ERS = 8'h10;
  localparam logic [7:0] C_SECT_ERS = 8'h30;
  localparam logic [7:0] C_BYP_EXIT = 8'h00;

  localparam int OFF_W       = 11;
  localparam int QRY_OFF     = 'h55;
  localparam int QRY_TBL_LEN = 'h4D;

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_pkg::*;
#(
  parameter int UNLOCK0 = 'h555,
  parameter int UNLOCK1 = 'h2AA,
  parameter int WIDX_W  = 9,
  parameter int SECT_SHIFT = 7,
  parameter int SECT_W  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [OFF_W-1:0]     off_i,
  input  logic [7:0]           cmd_i,
  input  logic [WIDX_W-1:0]    widx_i,
  input  logic                 erase_done_i,
  output seq_state_e           state_o,
  output logic                 prog_en_o,
  output logic                 ers_go_o,
  output logic                 ers_all_o,
  output logic [SECT_W-1:0]    ers_sect_o,
  output logic                 erase_req_o,
  output logic                 erase_all_o,
  output logic [SECT_W-1:0]    erase_sect_o
);

  localparam logic [OFF_W-1:0] U0 = OFF_W'(UNLOCK0);
  localparam logic [OFF_W-1:0] U1 = OFF_W'(UNLOCK1);
  localparam logic [OFF_W-1:0] QO = OFF_W'(QRY_OFF);

  seq_state_e state_q, state_d;
  logic       byp_q, byp_d;

  logic hit_u0, hit_u1;
  assign hit_u0 = (off_i == U0);
  assign hit_u1 = (off_i == U1);

  always_comb begin
    state_d   = state_q;
    byp_d     = byp_q;
    prog_en_o = 1'b0;
    ers_go_o  = 1'b0;
    ers_all_o = 1'b0;
    if (state_q == ST_ERASING && erase_done_i) begin
      state_d = byp_q ? ST_CMD : ST_READ;
    end else if (we_i) begin
      if (cmd_i == C_RESET && state_q != ST_PROG && state_q != ST_ERASING) begin
        if (state_q == ST_AUTO_QRY) begin
          state_d = ST_AUTO;
        end else begin
          state_d = ST_READ;
          byp_d   = 1'b0;
        end
      end else begin
        // default for every mismatch: back to read array, bypass dropped
        state_d = ST_READ;
        byp_d   = 1'b0;
        unique case (state_q)
          ST_READ: begin
            if (off_i == QO && cmd_i == C_QUERY) state_d = ST_QRY;
            else if (hit_u0 && cmd_i == C_UNLOCK_A) state_d = ST_UNL1;
          end
          ST_UNL1: begin
            if (hit_u1 && cmd_i == C_UNLOCK_B) state_d = ST_CMD;
          end
          ST_CMD: begin
            if (byp_q || hit_u0) begin
              byp_d = byp_q;
              unique case (cmd_i)
                C_BYPASS:  begin state_d = ST_CMD; byp_d = 1'b1; end
                C_ERASE:   state_d = ST_ERS_UNL0;
                C_AUTOSEL: state_d = ST_AUTO;
                C_PROGRAM: state_d = ST_PROG;
                default: begin state_d = ST_READ; byp_d = 1'b0; end
              endcase
            end
          end
          ST_PROG: begin
            prog_en_o = 1'b1;
            byp_d     = byp_q;
            state_d   = byp_q ? ST_CMD : ST_READ;
          end
          ST_AUTO: begin
            if (!(byp_q && cmd_i == C_BYP_EXIT) && off_i == QO && cmd_i == C_QUERY) begin
              state_d = ST_AUTO_QRY;
              byp_d   = byp_q;
            end
          end
          ST_ERS_UNL0: begin
            if (hit_u0 && cmd_i == C_UNLOCK_A) begin
              state_d = ST_ERS_UNL1;
              byp_d   = byp_q;
            end
          end
          ST_ERS_UNL1: begin
            if (hit_u1 && cmd_i == C_UNLOCK_B) begin
              state_d = ST_ERS_CMD;
              byp_d   = byp_q;
            end
          end
          ST_ERS_CMD: begin
            if (cmd_i == C_CHIP_ERS && hit_u0) begin
              ers_go_o  = 1'b1;
              ers_all_o = 1'b1;
              state_d   = ST_ERASING;
              byp_d     = byp_q;
            end else if (cmd_i == C_SECT_ERS) begin
              ers_go_o = 1'b1;
              state_d  = ST_ERASING;
              byp_d    = byp_q;
            end
          end
          ST_ERASING: begin
            state_d = ST_ERASING;
            byp_d   = byp_q;
          end
          default: ;
        endcase
      end
    end
  end

  assign ers_sect_o = widx_i[WIDX_W-1:SECT_SHIFT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_READ;
      byp_q        <= 1'b0;
      erase_req_o  <= 1'b0;
      erase_all_o  <= 1'b0;
      erase_sect_o <= '0;
    end else begin
      state_q     <= state_d;
      byp_q       <= byp_d;
      erase_req_o <= ers_go_o;
      if (ers_go_o) begin
        erase_all_o  <= ers_all_o;
        erase_sect_o <= ers_sect_o;
      end
    end
  end

  assign state_o = state_q;

  AST_UNLOCK_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UNL1 && we_i && !(hit_u1 && cmd_i == C_UNLOCK_B)) |=> state_q == ST_READ); // R2
  AST_QRY_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QRY && we_i) |=> (state_q == ST_READ && !byp_q)); // R6
  AST_NESTED_QRY_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AUTO_QRY && we_i && cmd_i == C_RESET) |=> state_q == ST_AUTO); // R7
  AST_ERASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERASING && !erase_done_i) |=> state_q == ST_ERASING); // R11
  AST_ERASE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |=> !erase_req_o); // R10
  AST_REQ_IN_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> state_q == ST_ERASING); // R10

endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 512,
  parameter int SECT_SHIFT = 7,
  parameter int SECT_W     = 2,
  localparam int WIDX_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_i,
  input  logic [WIDX_W-1:0] prog_idx_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              ers_en_i,
  input  logic              ers_all_i,
  input  logic [SECT_W-1:0] ers_sect_i,
  input  logic [WIDX_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] old_w;

  assign old_w = mem_q[prog_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (ers_en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ers_all_i || (SECT_W'(i >> SECT_SHIFT) == ers_sect_i)) mem_q[i] <= '1;
      end
    end else if (prog_en_i) begin
      mem_q[prog_idx_i] <= old_w & prog_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_i && !ers_en_i) |=> ((mem_q[$past(prog_idx_i)] & ~$past(old_w)) == '0)); // R4

endmodule

// File: rtl/nor_read_path.sv
module nor_read_path
  import nor_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 512,
  parameter int SECT_WORDS = 128,
  parameter logic [DATA_W-1:0] ID0 = '0,
  parameter logic [DATA_W-1:0] ID1 = '0,
  parameter logic [DATA_W-1:0] ID2 = '1,
  parameter logic [DATA_W-1:0] ID3 = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  seq_state_e        state_i,
  input  logic              ers_go_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] arr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int BYTES      = DATA_W / 8;
  localparam int CHIP_LOG2  = $clog2(DEPTH * BYTES);
  localparam int NSECT      = DEPTH / SECT_WORDS;
  localparam int SECT_BYTES = SECT_WORDS * BYTES;

  function automatic logic [7:0] qry_byte(input logic [OFF_W-1:0] o);
    logic [7:0] b;
    b = 8'h00;
    unique case (o)
      11'h10: b = 8'h51;
      11'h11: b = 8'h52;
      11'h12: b = 8'h59;
      11'h13: b = 8'h02;
      11'h15: b = 8'h40;
      11'h1B: b = 8'h27;
      11'h1C: b = 8'h36;
      11'h1F: b = 8'h07;
      11'h21: b = 8'h09;
      11'h22: b = 8'h0C;
      11'h23: b = 8'h01;
      11'h25: b = 8'h0A;
      11'h26: b = 8'h0D;
      11'h27: b = 8'(CHIP_LOG2);
      11'h28: b = 8'h02;
      11'h2C: b = 8'h01;
      11'h2D: b = 8'(NSECT - 1);
      11'h2E: b = 8'((NSECT - 1) >> 8);
      11'h2F: b = 8'(SECT_BYTES >> 8);
      11'h30: b = 8'(SECT_BYTES >> 16);
      11'h40: b = 8'h50;
      11'h41: b = 8'h52;
      11'h42: b = 8'h49;
      11'h43: b = 8'h31;
      11'h44: b = 8'h30;
      11'h46: b = 8'h02;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  logic              tog_q;
  logic [DATA_W-1:0] id_word, qry_word, stat_word, sel_word;
  logic              ph;

  always_comb begin
    unique case (off_i)
      11'h000: id_word = ID0;
      11'h001: id_word = ID1;
      11'h002: id_word = '0;
      11'h00E: id_word = (&ID2) ? arr_i : ID2;
      11'h00F: id_word = (&ID3) ? arr_i : ID3;
      default: id_word = arr_i;
    endcase
  end

  assign qry_word = (off_i < OFF_W'(QRY_TBL_LEN)) ? DATA_W'(qry_byte(off_i)) : '0;

  assign ph        = ~tog_q;
  assign stat_word = DATA_W'({1'b0, ph, 2'b00, 1'b1, ph, 2'b00});

  always_comb begin
    unique case (state_i)
      ST_AUTO:               sel_word = id_word;
      ST_QRY, ST_AUTO_QRY:   sel_word = qry_word;
      ST_ERASING:            sel_word = stat_word;
      default:               sel_word = arr_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (ers_go_i) tog_q <= 1'b0;
      else if (re_i && state_i == ST_ERASING) tog_q <= ~tog_q;
      if (re_i) rdata_o <= sel_word;
    end
  end

  AST_STATUS_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && state_i == ST_ERASING) |=> (rdata_o[7] == 1'b0 && rdata_o[3] && rdata_o[6] == rdata_o[2])); // R11

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 12,
  parameter int DEPTH      = 512,
  parameter int SECT_WORDS = 128,
  parameter int UNLOCK0    = 'h555,
  parameter int UNLOCK1    = 'h2AA,
  parameter logic [DATA_W-1:0] ID0 = 'h0001,
  parameter logic [DATA_W-1:0] ID1 = 'h227E,
  parameter logic [DATA_W-1:0] ID2 = '1,
  parameter logic [DATA_W-1:0] ID3 = 'h2201,
  localparam int NSECT     = DEPTH / SECT_WORDS,
  localparam int SECT_W    = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              erase_req_o,
  output logic              erase_all_o,
  output logic [SECT_W-1:0] erase_sect_o,
  input  logic              erase_done_i
);

  localparam int SHIFT      = $clog2(DATA_W / 8);
  localparam int WIDX_W     = $clog2(DEPTH);
  localparam int SECT_SHIFT = $clog2(SECT_WORDS);
  localparam int WA_W       = ADDR_W - SHIFT;

  logic [WA_W-1:0]   word_addr;
  logic [OFF_W-1:0]  off;
  logic [WIDX_W-1:0] widx;
  seq_state_e        state;
  logic              prog_en, ers_go, ers_all;
  logic [SECT_W-1:0] ers_sect;
  logic [DATA_W-1:0] arr_word;

  assign word_addr = addr_i[ADDR_W-1:SHIFT];
  assign off       = word_addr[OFF_W-1:0];
  assign widx      = word_addr[WIDX_W-1:0];

  nor_cmd_fsm #(
    .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1), .WIDX_W(WIDX_W),
    .SECT_SHIFT(SECT_SHIFT), .SECT_W(SECT_W)
  ) u_fsm (
    .clk_i, .rst_ni, .we_i,
    .off_i(off), .cmd_i(wdata_i[7:0]), .widx_i(widx),
    .erase_done_i,
    .state_o(state), .prog_en_o(prog_en), .ers_go_o(ers_go),
    .ers_all_o(ers_all), .ers_sect_o(ers_sect),
    .erase_req_o, .erase_all_o, .erase_sect_o
  );

  nor_array #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .SECT_SHIFT(SECT_SHIFT), .SECT_W(SECT_W)
  ) u_array (
    .clk_i, .rst_ni,
    .prog_en_i(prog_en), .prog_idx_i(widx), .prog_data_i(wdata_i),
    .ers_en_i(ers_go), .ers_all_i(ers_all), .ers_sect_i(ers_sect),
    .rd_idx_i(widx), .rd_data_o(arr_word)
  );

  nor_read_path #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .SECT_WORDS(SECT_WORDS),
    .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)
  ) u_rd (
    .clk_i, .rst_ni, .re_i,
    .state_i(state), .ers_go_i(ers_go), .off_i(off), .arr_i(arr_word),
    .rdata_o
  );

endmodule

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;

  localparam logic [11:0] U0B = 12'hAAA;
  localparam logic [11:0] U1B = 12'h554;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0, done = 1'b0;
  logic [15:0] rdata;
  logic        ereq, eall;
  logic [1:0]  esect;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] model [512];

  always #2.5 clk = ~clk;

  nor_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata),
    .erase_req_o(ereq), .erase_all_o(eall), .erase_sect_o(esect),
    .erase_done_i(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic unlock();
    wr(U0B, 16'h00AA); wr(U1B, 16'h0055);
  endtask

  task automatic prog(input int idx, input logic [15:0] d);
    unlock(); wr(U0B, 16'h00A0); wr(12'(idx << 1), d);
    model[idx] = model[idx] & d;
  endtask

  task automatic rd_chk(input int idx, input string tag);
    logic [15:0] v;
    rd(12'(idx << 1), v);
    chk(tag, 32'(v), 32'(model[idx]));
  endtask

  task automatic rd_off(input int off, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    rd(12'(off << 1), v);
    chk(tag, 32'(v), 32'(exp));
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic erase_setup();
    unlock(); wr(U0B, 16'h0080); unlock();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int seed;
    seed = $urandom(32'h5EED1234);
    for (int i = 0; i < 512; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1
    rd_chk(0, "R1 reset array");
    rd_chk(511, "R1 reset array top");
    chk("R1 no request", 32'(ereq), 0);

    // R4, R12
    prog(5, 16'h1234);
    rd_chk(5, "R12 R4 program");
    prog(5, 16'h00FF);
    rd_chk(5, "R4 AND program");

    // R2 bad second cycle
    wr(U0B, 16'h00AA); wr(12'h556, 16'h0055); wr(U0B, 16'h00A0); wr(12'h00A, 16'h0000);
    rd_chk(5, "R2 bad unlock addr");
    wr(U0B, 16'h00AA); wr(U1B, 16'h0056); wr(U0B, 16'h00A0); wr(12'h00A, 16'h0000);
    rd_chk(5, "R2 bad unlock data");

    // R3 unknown command
    unlock(); wr(U0B, 16'h0077); wr(12'h00A, 16'h0000);
    rd_chk(5, "R3 unknown command");
    unlock(); wr(12'h100, 16'h00A0); wr(12'h00A, 16'h0000);
    rd_chk(5, "R3 command address");

    // R12 unshifted address
    wr(12'h555, 16'h00AA); wr(U1B, 16'h0055); wr(U0B, 16'h00A0); wr(12'h00A, 16'h0000);
    rd_chk(5, "R12 unshifted unlock");

    // R5 bypass
    unlock(); wr(U0B, 16'h0020);
    wr(12'h000, 16'h00A0); wr(12'(7 << 1), 16'hF0F0); model[7] &= 16'hF0F0;
    wr(12'h3C6, 16'h00A0); wr(12'(8 << 1), 16'h0F0F); model[8] &= 16'h0F0F;
    rd_chk(7, "R5 bypass program");
    rd_chk(8, "R5 bypass second program");
    wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
    wr(U0B, 16'h00A0); wr(12'(9 << 1), 16'h0000);
    rd_chk(9, "R5 bypass exit");

    // R9 autoselect
    prog(14, 16'hA5A5);
    prog(32, 16'h5A5A);
    unlock(); wr(U0B, 16'h0090);
    rd_off(0, 16'h0001, "R9 ID0");
    rd_off(1, 16'h227E, "R9 ID1");
    rd_off(2, 16'h0000, "R9 protect word");
    rd_off(14, model[14], "R9 ID2 all ones falls to array");
    rd_off(15, 16'h2201, "R9 ID3");
    rd_off(32, model[32], "R9 other offset");

    // R7 nested query
    wr(12'h0AA, 16'h0098);
    rd_off('h10, 16'h0051, "R7 nested query");
    wr(12'h000, 16'h00F0);
    rd_off(0, 16'h0001, "R7 back to autoselect");
    wr(12'h000, 16'h00F0);
    rd_chk(0, "R8 reset to read");

    // R6 query
    wr(12'h0AA, 16'h0098);
    rd_off('h11, 16'h0052, "R6 table R");
    rd_off('h12, 16'h0059, "R6 table Y");
    rd_off('h27, 16'h000A, "R6 size byte");
    rd_off('h4D, 16'h0000, "R6 past table");
    wr(12'h000, 16'h0000);
    rd_chk('h11, "R6 write leaves query");

    // R8 F0 as program data
    prog(3, 16'h00F0);
    rd_chk(3, "R8 F0 programmed");
    unlock(); wr(12'h000, 16'h00F0); wr(U0B, 16'h00A0); wr(12'(3 << 1), 16'h0000);
    rd_chk(3, "R8 F0 resets after unlock");

    // R10 sector erase
    prog(130, 16'h0000); prog(200, 16'h1111);
    erase_setup(); wr(12'(130 << 1), 16'h0030);
    chk("R10 request", 32'(ereq), 1);
    chk("R10 sector kind", 32'(eall), 0);
    chk("R10 sector index", 32'(esect), 1);
    for (int i = 128; i < 256; i++) model[i] = 16'hFFFF;
    rd(12'h000, v);
    chk("R10 request one cycle", 32'(ereq), 0);
    chk("R11 status first", 32'(v), 32'h4C);
    rd(12'h000, v);
    chk("R11 status second", 32'(v), 32'h08);
    wr(12'h000, 16'h00F0);
    rd(12'h000, v);
    chk("R11 F0 ignored", 32'(v), 32'h4C);
    pulse_done();
    rd_chk(130, "R10 sector erased");
    rd_chk(200, "R10 sector erased 2");
    rd_chk(5, "R10 other sector kept");

    // R10 bad chip erase address
    erase_setup(); wr(12'h100, 16'h0010);
    chk("R10 bad chip address", 32'(ereq), 0);
    rd_chk(5, "R10 bad chip no erase");

    // R10 chip erase
    erase_setup(); wr(U0B, 16'h0010);
    chk("R10 chip request", 32'(ereq), 1);
    chk("R10 chip kind", 32'(eall), 1);
    for (int i = 0; i < 512; i++) model[i] = 16'hFFFF;
    pulse_done();
    rd_chk(5, "R10 chip erased");
    rd_chk(7, "R10 chip erased 2");

    // R11 bypass erase returns to command wait
    unlock(); wr(U0B, 16'h0020);
    wr(12'h000, 16'h0080); unlock(); wr(12'(400 << 1), 16'h0030);
    chk("R11 bypass erase request", 32'(ereq), 1);
    pulse_done();
    wr(12'h010, 16'h00A0); wr(12'(20 << 1), 16'h1234); model[20] &= 16'h1234;
    rd_chk(20, "R11 bypass kept after erase");
    wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);

    // random programs against model
    for (int i = 0; i < 80; i++) begin
      int idx;
      logic [15:0] d;
      idx = int'($urandom % 512);
      d = 16'($urandom);
      prog(idx, d);
      rd_chk(int'($urandom % 512), "R4 random readback");
      rd_chk(idx, "R4 random program");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule